// File: doc/BRIEF.md
# Protection-Key Access Permission Checker

This block decides whether a single memory access may proceed. Two sources of permission are combined. The first is the read and write permission bits of the page being touched. The second is a per-thread rights register that holds two control bits for every protection key: an access-disable bit and a write-disable bit. The key itself is a small field carried in the translated page entry. The checker is given this field, the page bits and the kind of access, and one cycle later it returns a verdict: allow, or deny with a cause code. The cause code separates a plain page-permission violation from a key violation.

Software owns the rights register. It can write the register through a write port at any time and can read it back on a dedicated output. A context switch saves and restores the register this way. Only data reads and data writes are subject to key rights; instruction fetches pass this block untouched.

The key width is a parameter. The default is 4 bits, giving 16 keys. A value of 5 gives 32 keys, and the rights register grows to match.

Top module: `pkey_chk`

## Requirements
- R1: After reset the rights register reads as all zeros, `res_valid` is 0, and a data access whose page bits allow it is granted with cause 2'b00.
- R2: A request presented with `chk_valid`=1 on a rising edge produces `res_valid`=1 with its verdict after that same edge. A cycle without a request produces `res_valid`=0 after the edge.
- R3: For key k, the access-disable bit is bit 2k of the rights register. When that bit is set, a data read or data write using key k is denied with cause 2'b10 (key fault), even when both page bits grant the access.
- R4: For key k, the write-disable bit is bit 2k+1. When that bit is set, data writes using key k are denied with cause 2'b10, and data reads using key k stay allowed.
- R5: The bits that belong to one key have no effect on accesses that use any other key, and this includes the highest key number.
- R6: Access kinds 2'b10 and 2'b11 are instruction fetches. A fetch is always allowed with cause 2'b00, whatever the key rights and page bits say. Kind 2'b00 is a data read and kind 2'b01 is a data write.
- R7: A data read with `chk_page_rd`=0, or a data write with `chk_page_wr`=0, is denied with cause 2'b01 (page fault). This cause is reported even when the key would also deny the access.
- R8: A rights write takes effect for checks sampled on later edges. A check sampled on the same edge as the write uses the previous rights value.
- R9: `rights_rdata` shows the value that was last written through the write port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rights_we | input | 1 | Write strobe for the rights register |
| rights_wdata | input | 2*2**KEY_W | New rights value; bit 2k is access-disable and bit 2k+1 is write-disable for key k |
| rights_rdata | output | 2*2**KEY_W | Current rights value |
| chk_valid | input | 1 | Access check request |
| chk_key | input | KEY_W | Protection key taken from the page entry |
| chk_page_rd | input | 1 | Page allows reads |
| chk_page_wr | input | 1 | Page allows writes |
| chk_kind | input | 2 | 00 data read, 01 data write, 1x instruction fetch |
| res_valid | output | 1 | Verdict valid |
| res_allow | output | 1 | Access allowed |
| res_cause | output | 2 | 00 none, 01 page fault, 10 key fault |

## Verification
The bench builds the checker with a key width of 4, so the rights register is 32 bits wide. This lets it exercise key 15, whose control bits sit at positions 30 and 31, next to low and middle keys. That covers the top end of the bit mapping and shows that neighbouring keys do not interfere. The bench constants come from one parameter, so the same scenarios can be run on the 5-bit variant, where key 31 reaches bits 62 and 63.

// File: rtl/pkey_chk_pkg.sv
package pkey_chk_pkg;

  typedef enum logic [1:0] {
    ACC_READ      = 2'b00,
    ACC_WRITE     = 2'b01,
    ACC_FETCH     = 2'b10,
    ACC_FETCH_ALT = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_PAGE = 2'b01,
    CAUSE_KEY  = 2'b10
  } cause_e;

  typedef struct packed {
    logic   allow;
    cause_e cause;
  } verdict_t;

endpackage

// File: rtl/pkey_rst_sync.sv
module pkey_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/pkey_rights_reg.sv
module pkey_rights_reg #(
  parameter int RIGHTS_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [RIGHTS_W-1:0] wdata,
  output logic [RIGHTS_W-1:0] q
);

  logic [RIGHTS_W-1:0] rights_q;
  logic [RIGHTS_W-1:0] rights_d;

  always_comb begin
    rights_d = rights_q;
    if (we) rights_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rights_q <= '0;
    else        rights_q <= rights_d;
  end

  assign q = rights_q;

  AST_RIGHTS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (q == $past(wdata))); // R9

  AST_RIGHTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q)); // R8

endmodule

// File: rtl/pkey_decide.sv
module pkey_decide
  import pkey_chk_pkg::*;
#(
  parameter int KEY_W = 4
) (
  input  logic [KEY_W-1:0]          key,
  input  logic [2*(1<<KEY_W)-1:0]   rights,
  input  logic                      page_rd,
  input  logic                      page_wr,
  input  logic [1:0]                kind,
  output verdict_t                  verdict
);

  localparam int NKEYS = 1 << KEY_W;

  logic [NKEYS-1:0] ad_vec;
  logic [NKEYS-1:0] wd_vec;

  for (genvar k = 0; k < NKEYS; k++) begin : g_key
    assign ad_vec[k] = rights[2*k];
    assign wd_vec[k] = rights[2*k+1];
  end

  logic is_data;
  logic is_write;
  logic page_ok;
  logic key_ok;

  always_comb begin
    is_data  = (kind[1] == 1'b0);
    is_write = (kind == ACC_WRITE);
    page_ok  = is_write ? page_wr : page_rd;
    key_ok   = !ad_vec[key] && !(is_write && wd_vec[key]);
    if (!is_data) begin
      verdict = '{allow: 1'b1, cause: CAUSE_NONE};
    end else if (!page_ok) begin
      verdict = '{allow: 1'b0, cause: CAUSE_PAGE};
    end else if (!key_ok) begin
      verdict = '{allow: 1'b0, cause: CAUSE_KEY};
    end else begin
      verdict = '{allow: 1'b1, cause: CAUSE_NONE};
    end
  end

endmodule

// File: rtl/pkey_chk.sv
module pkey_chk
  import pkey_chk_pkg::*;
#(
  parameter int KEY_W = 4,
  localparam int RIGHTS_W = 2 * (1 << KEY_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rights_we,
  input  logic [RIGHTS_W-1:0] rights_wdata,
  output logic [RIGHTS_W-1:0] rights_rdata,
  input  logic                chk_valid,
  input  logic [KEY_W-1:0]    chk_key,
  input  logic                chk_page_rd,
  input  logic                chk_page_wr,
  input  logic [1:0]          chk_kind,
  output logic                res_valid,
  output logic                res_allow,
  output logic [1:0]          res_cause
);

  logic                rst_n_sync;
  logic [RIGHTS_W-1:0] rights_q;
  verdict_t            verdict_c;

  pkey_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  pkey_rights_reg #(.RIGHTS_W(RIGHTS_W)) u_rights (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .we    (rights_we),
    .wdata (rights_wdata),
    .q     (rights_q)
  );

  pkey_decide #(.KEY_W(KEY_W)) u_decide (
    .key     (chk_key),
    .rights  (rights_q),
    .page_rd (chk_page_rd),
    .page_wr (chk_page_wr),
    .kind    (chk_kind),
    .verdict (verdict_c)
  );

  logic     valid_q, valid_d;
  verdict_t res_q, res_d;
  logic     res_en;

  always_comb begin
    valid_d = chk_valid;
    res_en  = chk_valid;
    res_d   = res_q;
    if (res_en) res_d = verdict_c;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      valid_q <= 1'b0;
      res_q   <= '{allow: 1'b0, cause: CAUSE_NONE};
    end else begin
      valid_q <= valid_d;
      res_q   <= res_d;
    end
  end

  assign rights_rdata = rights_q;
  assign res_valid    = valid_q;
  assign res_allow    = res_q.allow;
  assign res_cause    = res_q.cause;

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n_sync)
    chk_valid |=> res_valid); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !chk_valid |=> !res_valid); // R2

  AST_FETCH_PASSES: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (chk_valid && chk_kind[1]) |=> (res_allow && res_cause == CAUSE_NONE)); // R6

  AST_PAGE_FIRST: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (chk_valid && !chk_kind[1] && !(chk_kind[0] ? chk_page_wr : chk_page_rd))
    |=> (!res_allow && res_cause == CAUSE_PAGE)); // R7

  AST_KEY_AD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (chk_valid && chk_kind == ACC_READ && chk_page_rd && rights_q[{chk_key, 1'b0}])
    |=> (!res_allow && res_cause == CAUSE_KEY)); // R3

  AST_WD_READ_OK: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (chk_valid && chk_kind == ACC_READ && chk_page_rd && !rights_q[{chk_key, 1'b0}])
    |=> res_allow); // R4

  AST_VERDICT_CONSISTENT: assert property (@(posedge clk) disable iff (!rst_n_sync)
    res_valid |-> (res_allow == (res_cause == CAUSE_NONE))); // R3

endmodule

// File: tb/pkey_chk_bench.sv
module pkey_chk_bench;

  localparam int KW    = 4;
  localparam int NK    = 1 << KW;
  localparam int RW    = 2 * NK;
  localparam int TOPK  = NK - 1;

  logic          clk;
  logic          rst_n;
  logic          rights_we;
  logic [RW-1:0] rights_wdata;
  logic [RW-1:0] rights_rdata;
  logic          chk_valid;
  logic [KW-1:0] chk_key;
  logic          chk_page_rd;
  logic          chk_page_wr;
  logic [1:0]    chk_kind;
  logic          res_valid;
  logic          res_allow;
  logic [1:0]    res_cause;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  pkey_chk #(.KEY_W(KW)) u_pkey_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rights_we    (rights_we),
    .rights_wdata (rights_wdata),
    .rights_rdata (rights_rdata),
    .chk_valid    (chk_valid),
    .chk_key      (chk_key),
    .chk_page_rd  (chk_page_rd),
    .chk_page_wr  (chk_page_wr),
    .chk_kind     (chk_kind),
    .res_valid    (res_valid),
    .res_allow    (res_allow),
    .res_cause    (res_cause)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic expect_eq(input string req, input string what,
                           input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic write_rights(input logic [RW-1:0] val);
    @(negedge clk);
    rights_we    = 1'b1;
    rights_wdata = val;
    @(negedge clk);
    rights_we    = 1'b0;
  endtask

  task automatic run_check(input string req, input int key, input logic rd,
                           input logic wr, input logic [1:0] kind,
                           input logic exp_allow, input logic [1:0] exp_cause);
    @(negedge clk);
    chk_valid   = 1'b1;
    chk_key     = KW'(key);
    chk_page_rd = rd;
    chk_page_wr = wr;
    chk_kind    = kind;
    @(negedge clk);
    chk_valid   = 1'b0;
    expect_eq(req, "valid", 64'(res_valid), 64'd1);
    expect_eq(req, "allow", 64'(res_allow), 64'(exp_allow));
    expect_eq(req, "cause", 64'(res_cause), 64'(exp_cause));
  endtask

  task automatic t_reset;
    expect_eq("R1", "rights after reset", 64'(rights_rdata), 64'd0);
    expect_eq("R1", "valid after reset", 64'(res_valid), 64'd0);
    run_check("R1", 5, 1'b1, 1'b1, 2'b00, 1'b1, 2'b00);
    run_check("R1", 9, 1'b1, 1'b1, 2'b01, 1'b1, 2'b00);
  endtask

  task automatic t_latency;
    run_check("R2", 1, 1'b1, 1'b1, 2'b00, 1'b1, 2'b00);
    @(negedge clk);
    expect_eq("R2", "valid idle", 64'(res_valid), 64'd0);
  endtask

  task automatic t_access_disable;
    write_rights(RW'(1) << 4);  // AD of key 2
    expect_eq("R9", "readback", 64'(rights_rdata), 64'(RW'(1) << 4));
    run_check("R3", 2, 1'b1, 1'b1, 2'b00, 1'b0, 2'b10);
    run_check("R3", 2, 1'b1, 1'b1, 2'b01, 1'b0, 2'b10);
    run_check("R5", 3, 1'b1, 1'b1, 2'b00, 1'b1, 2'b00);
    run_check("R5", 1, 1'b1, 1'b1, 2'b01, 1'b1, 2'b00);
  endtask

  task automatic t_write_disable;
    write_rights(RW'(1) << 15);  // WD of key 7
    run_check("R4", 7, 1'b1, 1'b1, 2'b00, 1'b1, 2'b00);
    run_check("R4", 7, 1'b1, 1'b1, 2'b01, 1'b0, 2'b10);
    run_check("R5", 6, 1'b1, 1'b1, 2'b01, 1'b1, 2'b00);
  endtask

  task automatic t_top_key;
    write_rights(RW'(1) << (2 * TOPK));
    run_check("R5", TOPK, 1'b1, 1'b1, 2'b00, 1'b0, 2'b10);
    run_check("R5", TOPK - 1, 1'b1, 1'b1, 2'b00, 1'b1, 2'b00);
    write_rights(RW'(1) << (2 * TOPK + 1));
    run_check("R5", TOPK, 1'b1, 1'b1, 2'b00, 1'b1, 2'b00);
    run_check("R5", TOPK, 1'b1, 1'b1, 2'b01, 1'b0, 2'b10);
  endtask

  task automatic t_fetch;
    write_rights({RW{1'b1}});
    run_check("R6", 4, 1'b0, 1'b0, 2'b10, 1'b1, 2'b00);
    run_check("R6", 4, 1'b1, 1'b1, 2'b11, 1'b1, 2'b00);
  endtask

  task automatic t_page_priority;
    write_rights({RW{1'b1}});
    run_check("R7", 3, 1'b0, 1'b1, 2'b00, 1'b0, 2'b01);
    run_check("R7", 3, 1'b1, 1'b0, 2'b01, 1'b0, 2'b01);
    write_rights('0);
    run_check("R7", 3, 1'b1, 1'b0, 2'b00, 1'b1, 2'b00);
    run_check("R7", 3, 1'b0, 1'b1, 2'b01, 1'b1, 2'b00);
  endtask

  task automatic t_same_cycle;
    write_rights('0);
    @(negedge clk);
    rights_we    = 1'b1;
    rights_wdata = RW'(1) << 6;  // AD of key 3
    chk_valid    = 1'b1;
    chk_key      = KW'(3);
    chk_page_rd  = 1'b1;
    chk_page_wr  = 1'b1;
    chk_kind     = 2'b00;
    @(negedge clk);
    rights_we    = 1'b0;
    chk_valid    = 1'b0;
    expect_eq("R8", "old rights allow", 64'(res_allow), 64'd1);
    expect_eq("R8", "old rights cause", 64'(res_cause), 64'd0);
    run_check("R8", 3, 1'b1, 1'b1, 2'b00, 1'b0, 2'b10);
    expect_eq("R9", "readback", 64'(rights_rdata), 64'(RW'(1) << 6));
  endtask

  initial begin
    rst_n        = 1'b0;
    rights_we    = 1'b0;
    rights_wdata = '0;
    chk_valid    = 1'b0;
    chk_key      = '0;
    chk_page_rd  = 1'b0;
    chk_page_wr  = 1'b0;
    chk_kind     = 2'b00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_latency();
    t_access_disable();
    t_write_disable();
    t_top_key();
    t_fetch();
    t_page_priority();
    t_same_cycle();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule